// File: doc/BRIEF.md
# Duty-Cycled Receiver Polling Sequencer

This block saves power in a radio receiver by switching its signal path on only for short windows. It cycles through four modes. In sleep, only the oscillator and the polling logic run. In start-up, the signal path is powered while the analog chain settles. In bit-check, an external edge-timing checker decides whether a real transmitter is present. Receiving mode follows a passed check. A failed check sends the sequencer back to sleep.

The sleep window is the product of three values: a 5-bit sleep word, a small extension factor and a fixed prescale. It is counted in ticks of a prescaled clock strobe. If the product is zero, sleep lasts only one clock cycle, so the receiver polls back to back. Receiving mode can end in three ways:
- The end of the data stream returns the sequencer to bit-check, but only when noise suppression is enabled.
- An OFF command sends it to sleep.
- The forced-receive pin has its own behaviour. While it is held low, the sequencer is held in receiving mode. Its rising edge restarts polling with a full sleep window.

Top module: `rx_poll_seq`

## Requirements
- R1: A synchronous reset puts the sequencer in sleep mode. `active`, `path_en`, `chk_en` and `rx_mode` are all 0 while reset is high and in the first cycle after it.
- R2: On entry, the sleep timer is loaded with sleep_word × sleep_ext × PRESCALE. The timer counts down by one on each clock edge where `tick` is 1. Sleep mode lasts until the timer reaches zero, plus one clock cycle. With `tick` held at 1, sleep therefore lasts N+1 cycles. With `tick` at 0, sleep holds indefinitely.
- R3: When the sleep product is zero (sleep_word = 0 or sleep_ext = 0), sleep lasts exactly one cycle before start-up.
- R4: Start-up mode (`active` = 1, `chk_en` = 0, `rx_mode` = 0) lasts STARTUP_TICKS ticks plus one cycle, then bit-check mode begins. `chk_pass` and `chk_fail` have no effect during start-up.
- R5: In bit-check mode (`chk_en` = 1), `chk_pass` moves the sequencer to receiving mode on the next cycle. This holds even if `chk_fail` is also high.
- R6: In bit-check mode, `chk_fail` without `chk_pass` moves the sequencer to sleep on the next cycle.
- R7: In receiving mode with `noise_sup` = 1, `data_end` moves the sequencer to bit-check mode on the next cycle.
- R8: In receiving mode with `noise_sup` = 0, `data_end` is ignored and the sequencer stays in receiving mode.
- R9: `off_cmd` in receiving mode moves the sequencer to sleep on the next cycle, and it takes priority over `data_end`. In bit-check mode, `off_cmd` and `data_end` are ignored.
- R10: While `force_rx_n` is 0, the sequencer is in receiving mode from the next cycle on, whatever the other inputs are.
- R11: A rising edge on `force_rx_n` sends the sequencer to sleep on the next cycle with a freshly loaded sleep timer.
- R12: `active` and `path_en` are 1 in start-up, bit-check and receiving modes, and 0 in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Prescaled clock strobe that advances the mode timers |
| sleep_word | input | 5 | Sleep multiplier word |
| sleep_ext | input | EXT_W | Sleep extension factor |
| chk_pass | input | 1 | Bit check succeeded |
| chk_fail | input | 1 | Bit check failed |
| data_end | input | 1 | End of valid data stream |
| noise_sup | input | 1 | 1: return to bit-check when data ends |
| force_rx_n | input | 1 | Forced-receive pin, active low |
| off_cmd | input | 1 | OFF-command strobe |
| active | output | 1 | Receiver active indicator |
| path_en | output | 1 | Signal-path enable |
| chk_en | output | 1 | Bit-check enable |
| rx_mode | output | 1 | Receiving mode flag |

## Verification
The bench builds the block with PRESCALE = 4, STARTUP_TICKS = 3 and EXT_W = 2. With these values the longest sleep window (31 × 3 × 4 ticks) is only 373 cycles. That makes it practical to measure every sleep window exactly, from the zero-product single cycle to the maximum word and factor. It also leaves room to run the force-pin, OFF-command and tick-gap cases in a few thousand cycles.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [1:0] {
    M_SLEEP = 2'd0,
    M_START = 2'd1,
    M_CHECK = 2'd2,
    M_RECV  = 2'd3
  } rps_mode_e;

  // Dwell length in ticks for a mode that is being entered.
  function automatic logic [31:0] dwell_len(input rps_mode_e m,
                                            input logic [4:0] word,
                                            input logic [31:0] ext,
                                            input logic [31:0] prescale,
                                            input logic [31:0] startup);
    logic [31:0] r;
    case (m)
      M_SLEEP: r = 32'(word) * ext * prescale;
      M_START: r = startup;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rps_dwell_timer.sv
module rps_dwell_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load)
      cnt_q <= load_val;
    else if (tick && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rps_pin_edge.sv
module rps_pin_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic held_low,
  output logic rose
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_n;
  end

  assign held_low = ~pin_n;
  assign rose     = pin_n & ~prev_q;
endmodule

// File: rtl/rps_mode_fsm.sv
module rps_mode_fsm
  import rps_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      expired,
  input  logic      chk_pass,
  input  logic      chk_fail,
  input  logic      data_end,
  input  logic      noise_sup,
  input  logic      off_cmd,
  input  logic      held_low,
  input  logic      rose,
  output rps_mode_e mode_q,
  output rps_mode_e mode_d,
  output logic      enter
);
  always_comb begin
    mode_d = mode_q;
    if (held_low) begin
      mode_d = M_RECV;
    end else if (rose) begin
      mode_d = M_SLEEP;
    end else begin
      case (mode_q)
        M_SLEEP: if (expired) mode_d = M_START;
        M_START: if (expired) mode_d = M_CHECK;
        M_CHECK: begin
          if (chk_pass)      mode_d = M_RECV;
          else if (chk_fail) mode_d = M_SLEEP;
        end
        M_RECV: begin
          if (off_cmd)                    mode_d = M_SLEEP;
          else if (data_end && noise_sup) mode_d = M_CHECK;
        end
        default: mode_d = M_SLEEP;
      endcase
    end
  end

  assign enter = rst | (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= M_SLEEP;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/rx_poll_seq.sv
module rx_poll_seq
  import rps_pkg::*;
#(
  parameter int unsigned PRESCALE      = 1024,
  parameter int unsigned STARTUP_TICKS = 64,
  parameter int unsigned EXT_W         = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [4:0]       sleep_word,
  input  logic [EXT_W-1:0] sleep_ext,
  input  logic             chk_pass,
  input  logic             chk_fail,
  input  logic             data_end,
  input  logic             noise_sup,
  input  logic             force_rx_n,
  input  logic             off_cmd,
  output logic             active,
  output logic             path_en,
  output logic             chk_en,
  output logic             rx_mode
);
  localparam int unsigned EXT_MAX   = (1 << EXT_W) - 1;
  localparam int unsigned SLEEP_MAX = 31 * EXT_MAX * PRESCALE;
  localparam int unsigned DWELL_MAX = (SLEEP_MAX > STARTUP_TICKS) ? SLEEP_MAX : STARTUP_TICKS;
  localparam int unsigned CNT_W     = $clog2(DWELL_MAX + 1);

  rps_mode_e        mode_q, mode_d, load_mode;
  logic             enter;
  logic             timer_zero;
  logic             pin_low, pin_rise;
  logic [CNT_W-1:0] load_val;

  rps_pin_edge u_pin (
    .clk      (clk),
    .rst      (rst),
    .pin_n    (force_rx_n),
    .held_low (pin_low),
    .rose     (pin_rise)
  );

  rps_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .expired   (timer_zero),
    .chk_pass  (chk_pass),
    .chk_fail  (chk_fail),
    .data_end  (data_end),
    .noise_sup (noise_sup),
    .off_cmd   (off_cmd),
    .held_low  (pin_low),
    .rose      (pin_rise),
    .mode_q    (mode_q),
    .mode_d    (mode_d),
    .enter     (enter)
  );

  assign load_mode = rst ? M_SLEEP : mode_d;
  assign load_val  = CNT_W'(dwell_len(load_mode, sleep_word, 32'(sleep_ext),
                                      32'(PRESCALE), 32'(STARTUP_TICKS)));

  rps_dwell_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .load     (enter),
    .load_val (load_val),
    .tick     (tick),
    .expired  (timer_zero)
  );

  assign active  = (mode_q != M_SLEEP);
  assign path_en = (mode_q == M_START) | (mode_q == M_CHECK) | (mode_q == M_RECV);
  assign chk_en  = (mode_q == M_CHECK);
  assign rx_mode = (mode_q == M_RECV);
endmodule

// File: rtl/rps_checker.sv
module rps_checker (
  input logic clk,
  input logic rst,
  input logic chk_pass,
  input logic chk_fail,
  input logic data_end,
  input logic noise_sup,
  input logic force_rx_n,
  input logic off_cmd,
  input logic active,
  input logic chk_en,
  input logic rx_mode,
  input logic timer_zero,
  input logic pin_rise
);
  logic in_start;
  assign in_start = active && !chk_en && !rx_mode;

  a_r1_reset_sleep: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!active && !chk_en && !rx_mode));

  a_r2_sleep_holds: assert property (@(posedge clk) disable iff (rst)
    (!active && !timer_zero && force_rx_n && !pin_rise) |=> !active);

  a_r3_sleep_exit: assert property (@(posedge clk) disable iff (rst)
    (!active && timer_zero && force_rx_n && !pin_rise) |=> (active && !chk_en && !rx_mode));

  a_r4_startup_holds: assert property (@(posedge clk) disable iff (rst)
    (in_start && !timer_zero && force_rx_n && !pin_rise) |=> (active && !chk_en && !rx_mode));

  a_r5_pass_recv: assert property (@(posedge clk) disable iff (rst)
    (chk_en && chk_pass && force_rx_n && !pin_rise) |=> rx_mode);

  a_r6_fail_sleep: assert property (@(posedge clk) disable iff (rst)
    (chk_en && !chk_pass && chk_fail && force_rx_n && !pin_rise) |=> !active);

  a_r7_end_recheck: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && data_end && noise_sup && !off_cmd && force_rx_n && !pin_rise) |=> chk_en);

  a_r8_end_ignored: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && !noise_sup && !off_cmd && force_rx_n && !pin_rise) |=> rx_mode);

  a_r9_off_sleep: assert property (@(posedge clk) disable iff (rst)
    (rx_mode && off_cmd && force_rx_n && !pin_rise) |=> !active);

  a_r10_force_recv: assert property (@(posedge clk) disable iff (rst)
    !force_rx_n |=> rx_mode);

  a_r11_rise_sleep: assert property (@(posedge clk) disable iff (rst)
    pin_rise |=> !active);
endmodule

bind rx_poll_seq rps_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .chk_pass   (chk_pass),
  .chk_fail   (chk_fail),
  .data_end   (data_end),
  .noise_sup  (noise_sup),
  .force_rx_n (force_rx_n),
  .off_cmd    (off_cmd),
  .active     (active),
  .chk_en     (chk_en),
  .rx_mode    (rx_mode),
  .timer_zero (timer_zero),
  .pin_rise   (pin_rise)
);

// File: tb/rx_poll_seq_tb.sv
`timescale 1ns/1ps
module rx_poll_seq_tb;
  localparam int unsigned PRESCALE = 4;
  localparam int unsigned STARTUP  = 3;
  localparam int unsigned EXT_W    = 2;

  typedef struct packed {
    logic [4:0]  w;
    logic [1:0]  e;
    logic        pass;
    logic        ns;
    logic [11:0] exp_sleep;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'd3,  2'd2, 1'b1, 1'b1, 12'd25},
    '{5'd0,  2'd3, 1'b0, 1'b1, 12'd1},
    '{5'd5,  2'd0, 1'b1, 1'b0, 12'd1},
    '{5'd1,  2'd1, 1'b0, 1'b0, 12'd5},
    '{5'd31, 2'd3, 1'b1, 1'b1, 12'd373},
    '{5'd2,  2'd3, 1'b1, 1'b0, 12'd25}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [4:0] sleep_word = '0;
  logic [EXT_W-1:0] sleep_ext = '0;
  logic chk_pass = 1'b0, chk_fail = 1'b0, data_end = 1'b0;
  logic noise_sup = 1'b1, force_rx_n = 1'b1, off_cmd = 1'b0;
  logic active, path_en, chk_en, rx_mode;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  rx_poll_seq #(.PRESCALE(PRESCALE), .STARTUP_TICKS(STARTUP), .EXT_W(EXT_W)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .sleep_word(sleep_word), .sleep_ext(sleep_ext),
    .chk_pass(chk_pass), .chk_fail(chk_fail), .data_end(data_end), .noise_sup(noise_sup),
    .force_rx_n(force_rx_n), .off_cmd(off_cmd),
    .active(active), .path_en(path_en), .chk_en(chk_en), .rx_mode(rx_mode)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode code seen at the ports: 0 sleep, 1 start-up, 2 bit-check, 3 receiving
  function automatic int port_mode();
    if (!active) return 0;
    if (chk_en)  return 2;
    if (rx_mode) return 3;
    return 1;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_mode(input int m, output int n);
    n = 0;
    while (port_mode() == m && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    // R1: reset state
    sleep_word = 5'd2; sleep_ext = 2'd1;
    repeat (2) @(negedge clk);
    check("R1 reset outputs", {active, path_en, chk_en, rx_mode}, 0);
    rst = 1'b0;
    check("R1 first cycle after reset", port_mode(), 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R8 R12
    for (int i = 0; i < 6; i++) begin
      sleep_word = VEC[i].w; sleep_ext = VEC[i].e; noise_sup = VEC[i].ns;
      do_reset();
      count_mode(0, n);
      check("R2/R3 sleep length", n, int'(VEC[i].exp_sleep));
      check("R12 path_en in start-up", int'(path_en), 1);
      count_mode(1, n);
      check("R4 start-up length", n, STARTUP + 1);
      chk_pass = VEC[i].pass; chk_fail = !VEC[i].pass;
      @(negedge clk);
      chk_pass = 1'b0; chk_fail = 1'b0;
      if (VEC[i].pass) begin
        check("R5 pass to receive", port_mode(), 3);
        data_end = 1'b1;
        @(negedge clk);
        data_end = 1'b0;
        if (VEC[i].ns) check("R7 data end to bit-check", port_mode(), 2);
        else           check("R8 data end ignored", port_mode(), 3);
      end else begin
        check("R6 fail to sleep", port_mode(), 0);
        check("R12 active low in sleep", int'(active | path_en), 0);
      end
    end

    // R4: pass during start-up ignored
    sleep_word = 5'd0; sleep_ext = 2'd1; noise_sup = 1'b1;
    do_reset();
    @(negedge clk);
    check("R3 zero word start-up", port_mode(), 1);
    chk_pass = 1'b1;
    @(negedge clk);
    chk_pass = 1'b0;
    check("R4 pass ignored in start-up", port_mode(), 1);
    count_mode(1, n);
    // R9: off_cmd and data_end ignored in bit-check
    off_cmd = 1'b1; data_end = 1'b1;
    @(negedge clk);
    off_cmd = 1'b0; data_end = 1'b0;
    check("R9 off ignored in bit-check", port_mode(), 2);
    // R5: pass wins over fail
    chk_pass = 1'b1; chk_fail = 1'b1;
    @(negedge clk);
    chk_pass = 1'b0; chk_fail = 1'b0;
    check("R5 pass priority", port_mode(), 3);
    // R9: off wins over data_end
    off_cmd = 1'b1; data_end = 1'b1;
    @(negedge clk);
    off_cmd = 1'b0; data_end = 1'b0;
    check("R9 off to sleep", port_mode(), 0);

    // R10 / R11: forced receive pin
    sleep_word = 5'd31; sleep_ext = 2'd3;
    do_reset();
    sleep_word = 5'd2; sleep_ext = 2'd1;
    force_rx_n = 1'b0;
    @(negedge clk);
    check("R10 force low to receive", port_mode(), 3);
    off_cmd = 1'b1;
    repeat (4) @(negedge clk);
    off_cmd = 1'b0;
    check("R10 held in receive", port_mode(), 3);
    force_rx_n = 1'b1;
    @(negedge clk);
    check("R11 rise to sleep", port_mode(), 0);
    count_mode(0, n);
    check("R11 full sleep after rise", n, 9);

    // R2: no ticks, sleep holds
    sleep_word = 5'd1; sleep_ext = 2'd1; tick = 1'b0;
    do_reset();
    repeat (20) @(negedge clk);
    check("R2 sleep holds without tick", port_mode(), 0);
    tick = 1'b1;
    count_mode(0, n);
    check("R2 sleep after ticks resume", n, 5);

    summary();
    $finish;
  end
endmodule